// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Flag Sleep Filter

This block receives characters from one asynchronous serial line. The line is sampled on a 16x oversampling enable that a separate baud-rate generator supplies. Each character is decoded, checked for parity and framing, and placed in a single-entry read buffer. The buffer keeps its value until a consumer reads it with a one-cycle read strobe.

Three options shape the data path. A line-reverse control inverts the incoming level before any decoding. A sleep control lets through only characters whose top data bit is set, so a node on a shared multi-drop line can ignore traffic until it is addressed. A data-inversion control presents the stored character bitwise inverted on the read port. The stored value, the sleep decision and the parity check are not changed by this inversion.

Top module: `uart_sleep_rx`

## Requirements
- R1: A frame is one low start bit, then 8 data bits with bit 0 first, then one even parity bit when parity_en_i=1 (none when 0), then one stop bit. Each bit lasts 16 ticks of baud_tick_i. An accepted character appears on rx_data_o with rx_valid_o=1.
- R2: Reception starts only if the line is still low when sampled at the middle of the start bit. A low pulse shorter than half a bit changes no output.
- R3: With sleep_en_i=1, a completed character with data bit 7 = 1 is stored and sets rx_valid_o.
- R4: With sleep_en_i=1, a completed character with data bit 7 = 0 is discarded. rx_data_o, rx_valid_o, parity_err_o, frame_err_o and overrun_o stay unchanged.
- R5: With data_inv_i=1, rx_data_o is the bitwise NOT of the stored character, and the change takes effect immediately. The sleep test on bit 7 and the parity check use the character as received, before this inversion.
- R6: With line_rev_i=1, the rxd_i level is inverted before decoding. This applies to the start, data, parity and stop bits alike, so the idle line is low.
- R7: parity_err_o is 1 for a stored character when parity_en_i=1 and the received parity bit differs from the XOR of the 8 data bits. Otherwise it is 0.
- R8: frame_err_o is 1 for a stored character whose stop bit samples low. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R9: When a character is stored while rx_valid_o=1 and rd_i=0, overrun_o is set and the newer character replaces the old one. rd_i=1 clears rx_valid_o and overrun_o.
- R10: After reset, rx_valid_o, overrun_o, parity_err_o and frame_err_o are 0, and rx_data_o is 0 when data_inv_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | 16x oversampling enable, one cycle wide |
| rxd_i | input | 1 | Serial receive line |
| line_rev_i | input | 1 | Invert the line level before decoding |
| parity_en_i | input | 1 | Frame carries an even parity bit |
| sleep_en_i | input | 1 | Store only characters with bit 7 set |
| data_inv_i | input | 1 | Present the stored character inverted |
| rd_i | input | 1 | Read strobe, consumes the buffer |
| rx_data_o | output | 8 | Stored character, after optional inversion |
| rx_valid_o | output | 1 | Buffer holds an unread character |
| parity_err_o | output | 1 | Parity error of the stored character |
| frame_err_o | output | 1 | Framing error of the stored character |
| overrun_o | output | 1 | An unread character was overwritten |

## Verification
A bit-counter or phase-counter fault shifts the sampling point or the bit order. That shows up as a wrong rx_data_o or a wrong parity flag on the very first frame, about one bit time after the stop bit. A fault in the sleep filter either stores a character with bit 7 clear or drops one with bit 7 set. This is visible on rx_valid_o one cycle after the stop bit is sampled. Faults in the overrun or read logic appear only after two frames without a read, or on the cycle after the read strobe. The bench therefore sends such pairs on purpose.

// File: rtl/uart_sleep_rx_pkg.sv
package uart_sleep_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic line_rev_i,
  output logic rx_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], rxd_i};
  end

  // R6: reversal ahead of every decoder stage
  assign rx_o = sh_q[STAGES-1] ^ line_rev_i;
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_sleep_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              parity_en_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q, frm_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) state_q <= ST_START;
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              par_q   <= 1'b0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == TOP) state_q <= parity_en_i ? ST_PAR : ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              par_q   <= rx_i ^ (^sh_q);
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              frm_q   <= !rx_i;
              done_q  <= 1'b1;
              state_q <= rx_i ? ST_IDLE : ST_WAIT_HI;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WAIT_HI: if (rx_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = sh_q;
  assign par_err_o = par_q;
  assign frm_err_o = frm_q;

  a_r2_start_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == MID && rx_i) |=> state_q == ST_IDLE);
  a_r8_wait_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick_i && cnt_q == LAST && !rx_i) |=> (frm_q && state_q == ST_WAIT_HI));
  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              sleep_en_i,
  input  logic              data_inv_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] buf_q;
  logic              valid_q, per_q, fer_q, ovr_q;
  logic              accept;

  // address filter looks at the character as received
  assign accept = done_i && (!sleep_en_i || data_i[DATA_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      valid_q <= 1'b0;
      per_q   <= 1'b0;
      fer_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (accept) begin
      buf_q   <= data_i;
      per_q   <= par_err_i;
      fer_q   <= frm_err_i;
      valid_q <= 1'b1;
      ovr_q   <= valid_q && !rd_i;
    end else if (rd_i) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign data_o    = buf_q ^ {DATA_W{data_inv_i}};
  assign valid_o   = valid_q;
  assign par_err_o = per_q;
  assign frm_err_o = fer_q;
  assign overrun_o = ovr_q;

  a_r3_flag_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && sleep_en_i && data_i[DATA_W-1]) |=> (valid_q && buf_q == $past(data_i)));
  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && sleep_en_i && !data_i[DATA_W-1] && !rd_i)
      |=> ($stable(buf_q) && $stable(valid_q) && $stable(ovr_q) && $stable(per_q) && $stable(fer_q)));
  a_r9_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && valid_q && !rd_i) |=> ovr_q);
  a_r9_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!valid_q && !ovr_q));
endmodule

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              rxd_i,
  input  logic              line_rev_i,
  input  logic              parity_en_i,
  input  logic              sleep_en_i,
  input  logic              data_inv_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              rx_line;
  logic              fr_done, fr_perr, fr_ferr;
  logic [DATA_W-1:0] fr_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rxd_i      (rxd_i),
    .line_rev_i (line_rev_i),
    .rx_o       (rx_line)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .rx_i        (rx_line),
    .parity_en_i (parity_en_i),
    .done_o      (fr_done),
    .data_o      (fr_data),
    .par_err_o   (fr_perr),
    .frm_err_o   (fr_ferr)
  );

  uart_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (fr_done),
    .data_i     (fr_data),
    .par_err_i  (fr_perr),
    .frm_err_i  (fr_ferr),
    .sleep_en_i (sleep_en_i),
    .data_inv_i (data_inv_i),
    .rd_i       (rd_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .par_err_o  (parity_err_o),
    .frm_err_o  (frame_err_o),
    .overrun_o  (overrun_o)
  );
endmodule

// File: tb/tb_uart_sleep_rx.sv
module tb_uart_sleep_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rev = 1'b0, pen = 1'b0, slp = 1'b0, inv = 1'b0, rd = 1'b0;
  logic [7:0] dout;
  logic       valid, perr, ferr, ovr;
  int         errors = 0, checks = 0;
  bit         done_flag = 0;

  always #4 clk = ~clk;

  uart_sleep_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .rxd_i(rxd),
    .line_rev_i(rev), .parity_en_i(pen), .sleep_en_i(slp), .data_inv_i(inv),
    .rd_i(rd), .rx_data_o(dout), .rx_valid_o(valid), .parity_err_o(perr),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // {data[15:8], sleep, inv, par_en, bad_par, bad_stop, exp_accept, 2'b0}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 6'b000001, 2'b00},
    {8'h3C, 6'b001001, 2'b00},
    {8'h3C, 6'b001101, 2'b00},
    {8'h81, 6'b011001, 2'b00},
    {8'hC3, 6'b100001, 2'b00},
    {8'h42, 6'b101000, 2'b00},
    {8'h7F, 6'b110010, 2'b00},
    {8'hFF, 6'b111111, 2'b00},
    {8'h00, 6'b000011, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b ^ rev;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pen) drive_bit((^d) ^ bad_par);
    drive_bit(!bad_stop);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic read_buf();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] last_d;
    logic       last_pe, last_fe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", valid, 0);
    chk("R10 overrun", ovr, 0);
    chk("R10 parity_err", perr, 0);
    chk("R10 frame_err", ferr, 0);
    chk("R10 data", dout, 0);
    last_d = 8'h00; last_pe = 0; last_fe = 0;

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic       acc, bp, bs;
      d = VEC[v][15:8];
      slp = VEC[v][7]; inv = VEC[v][6]; pen = VEC[v][5];
      bp = VEC[v][4]; bs = VEC[v][3]; acc = VEC[v][2];
      send(d, bp, bs);
      if (acc) begin
        last_d = d; last_pe = pen && bp; last_fe = bs;
        chk(slp ? "R3 valid" : "R1 valid", valid, 1);
      end else begin
        chk("R4 valid kept low", valid, 0);
      end
      chk(inv ? "R5 data inverted" : "R1 data", dout, last_d ^ {8{inv}});
      chk("R7 parity flag", perr, last_pe);
      chk("R8 frame flag", ferr, last_fe);
      chk("R4 overrun", ovr, 0);
      if (acc) begin
        read_buf();
        chk("R9 read clears valid", valid, 0);
      end
    end
    slp = 0; inv = 0; pen = 0;

    // R5 dynamic inversion of held data, no new frame
    send(8'h96, 0, 0);
    inv = 1'b1;
    @(negedge clk);
    chk("R5 live inversion", dout, 8'h69);
    inv = 1'b0;
    @(negedge clk);
    chk("R5 inversion removed", dout, 8'h96);
    read_buf();

    // R2 short low pulse ignored
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
    chk("R2 glitch valid", valid, 0);
    chk("R2 glitch data", dout, 8'h96);

    // R9 overrun
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    chk("R9 overrun set", ovr, 1);
    chk("R9 newest data", dout, 8'h22);
    read_buf();
    chk("R9 overrun cleared", ovr, 0);
    chk("R9 valid cleared", valid, 0);

    // R6 line reversal, idle line low
    rev = 1'b1;
    rxd = 1'b0;
    pen = 1'b1;
    repeat (96) @(negedge clk);
    send(8'h5A, 0, 0);
    chk("R6 reversed valid", valid, 1);
    chk("R6 reversed data", dout, 8'h5A);
    chk("R6 reversed parity ok", perr, 0);
    chk("R6 reversed stop ok", ferr, 0);
    read_buf();
    send(8'hE1, 1, 0);
    chk("R6 reversed parity err", perr, 1);
    chk("R6 reversed data 2", dout, 8'hE1);
    read_buf();

    finish_run();
  end
endmodule